// File: doc/BRIEF.md
# Routing Channel Connection Unit

This block links one pin of a logic block to the wires of a routing channel in a programmable array. One parameter fixes its kind. An input unit acts as a multiplexer: the pin receives the value of one chosen channel wire. An output unit acts as a demultiplexer: the pin drives any subset of the channel wires at once. A passthrough unit joins two neighbouring logic blocks directly and uses no channel wire. Each leg is bound to one channel wire through a parameter list, so any wire order can be set up.

Each leg has its own configuration bit. All bits sit in one serial shift chain that loads one bit per enabled clock. An input unit with more legs than one group holds is built in two levels. Groups of legs feed a second stage that has one bit per group, and the last group keeps its exact size, so sizes such as 12 or 20 legs are built exactly. A parameter can switch an input unit to binary codes: each group then holds a code and the second stage holds a group code. This uses fewer bits, and routing is the same for matching settings. Channel values are combined with AND/OR gating in place of shared tri-state lines.

Top module: `conn_block_mux`

## Requirements
- R1: On each clock with `cfgShiftEn` high, the chain takes `cfgDataIn` at its top bit and every bit moves one place toward bit 0. After L shifts, the bit that entered first sits at position 0. `cfgDataOut` shows bit 0. Reset clears every bit. With `cfgShiftEn` low, the bits do not change.
- R2: In one-hot mode, an input unit with N legs and group size G (default 8) has a chain of N bits when N <= G. When N > G it has N + ceil(N/G) bits. An output unit has N bits and a passthrough unit has 1 bit.
- R3: In code mode, each group of S legs uses ceil(log2 S) bits. A second stage over C groups adds ceil(log2 C) bits when C > 1. For N=12 that is 6 bits, for N=20 it is 10, and for N=8 it is 3 (five fewer than one-hot).
- R4: An input unit drives `pinOut` with the OR of the mapped wire values over all enabled legs. With no leg enabled, `pinOut` is 0. In one-hot mode, leg i is enabled by chain bit i.
- R5: When N > G, leg i belongs to group floor(i/G). Group k is enabled by one-hot chain bit N+k. A leg whose group is not enabled has no effect on `pinOut`.
- R6: In code mode, group k holds its code in the bits that follow the codes of the groups below it, starting at bit 0, least significant bit first. Code j enables leg k*G+j. The stage code comes after all group codes, and a stage code equal to k enables group k. A coded setting routes the same as the one-hot setting that enables the same leg and group.
- R7: With the map enabled, leg i uses channel wire `LEG_MAP[i*W +: W]`, where W = ceil(log2 `CHAN_W`). Without the map, leg i uses wire i mod `CHAN_W`.
- R8: An output unit drives `chanOut[w]` as `pinIn` AND (some enabled leg maps to w). A wire that no enabled leg maps to reads 0. `pinOut` is 0 for an output unit.
- R9: A passthrough unit drives `pinOut` as `pinIn` AND chain bit 0, and holds `chanOut` at 0.
- R10: An input unit holds `chanOut` at 0 for any setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rstN | input | 1 | Asynchronous active-low reset; clears the chain |
| cfgShiftEn | input | 1 | Shifts the chain by one bit on this clock |
| cfgDataIn | input | 1 | Serial bit entering the top of the chain |
| cfgDataOut | output | 1 | Chain bit 0, for linking to the next unit's chain |
| chanIn | input | CHAN_W | Channel wire values seen by the unit |
| pinIn | input | 1 | Value from the logic block (output and passthrough kinds) |
| pinOut | output | 1 | Value to the logic block (input and passthrough kinds) |
| chanOut | output | CHAN_W | Values the unit drives onto the channel, 0 where not driven |

## Verification
Routing is purely combinational from the chain bits and the channel or pin inputs. So `pinOut` and `chanOut` follow a new input value within the same cycle. A new chain bit takes effect right after the rising edge that shifts it in. The bench changes inputs and shift controls on the falling edge and samples 2 ns later, so it sees the value of the last completed shift and never races an edge. When it measures the chain length, the bench samples `cfgDataOut` 1 ns after each shifting edge and counts the edges until a marker bit reaches the far end.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;

  typedef enum logic [1:0] {
    UNIT_IN   = 2'd0,
    UNIT_OUT  = 2'd1,
    UNIT_PASS = 2'd2
  } unit_kind_e;

  // number of first-level groups for n legs of group size g
  function automatic int grpCount(input int n, input int g);
    return (n <= g) ? 1 : (n + g - 1) / g;
  endfunction

  // legs in group k (last group keeps its exact remainder)
  function automatic int grpSize(input int n, input int g, input int k);
    int rest;
    rest = n - k * g;
    return (rest < g) ? rest : g;
  endfunction

  // configuration bits used by group k
  function automatic int selWidth(input int n, input int g, input int k, input bit dec);
    int s;
    s = grpSize(n, g, k);
    return dec ? $clog2(s) : s;
  endfunction

  // first configuration bit of group k (groups below it come first)
  function automatic int selOffset(input int n, input int g, input int k, input bit dec);
    int off;
    off = 0;
    for (int j = 0; j < k; j++) off += selWidth(n, g, j, dec);
    return off;
  endfunction

  // second-stage bits, zero for a single-level unit
  function automatic int stageWidth(input int n, input int g, input bit dec);
    int c;
    c = grpCount(n, g);
    if (c == 1) return 0;
    return dec ? $clog2(c) : c;
  endfunction

  function automatic int cfgLength(input unit_kind_e kind, input int n, input int g, input bit dec);
    int len;
    case (kind)
      UNIT_IN:  len = selOffset(n, g, grpCount(n, g), dec) + stageWidth(n, g, dec);
      UNIT_OUT: len = n;
      default:  len = 1;
    endcase
    return (len < 1) ? 1 : len;
  endfunction

endpackage

// File: rtl/cbm_cfg_chain.sv
`timescale 1ns/1ps
module cbm_cfg_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           shiftEn,
  input  logic           dataIn,
  output logic [LEN-1:0] cfgVec,
  output logic           dataOut
);

  logic [LEN-1:0] cfgReg;

  generate
    if (LEN == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        cfgReg <= '0;
        else if (shiftEn) cfgReg <= dataIn;
      end
    end else begin : gMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        cfgReg <= '0;
        else if (shiftEn) cfgReg <= {dataIn, cfgReg[LEN-1:1]};
      end
    end
  endgenerate

  assign cfgVec  = cfgReg;
  assign dataOut = cfgReg[0];

endmodule

// File: rtl/cbm_select.sv
`timescale 1ns/1ps
module cbm_select
  import cbm_pkg::*;
#(
  parameter unit_kind_e KIND       = UNIT_IN,
  parameter int         NUM_LEGS   = 12,
  parameter int         GRP        = 8,
  parameter bit         SEL_DECODE = 1'b0,
  parameter int         GRP_N      = 2,
  parameter int         CFG_BITS   = 14
) (
  input  logic [CFG_BITS-1:0] cfgVec,
  output logic [NUM_LEGS-1:0] legEn,
  output logic [GRP_N-1:0]    grpEn
);

  generate
    if (KIND == UNIT_IN && SEL_DECODE) begin : gCode
      for (genvar k = 0; k < GRP_N; k++) begin : gGrp
        localparam int SZ  = grpSize(NUM_LEGS, GRP, k);
        localparam int W   = selWidth(NUM_LEGS, GRP, k, 1'b1);
        localparam int OFF = selOffset(NUM_LEGS, GRP, k, 1'b1);
        if (W == 0) begin : gSingle
          assign legEn[k*GRP] = 1'b1;
        end else begin : gDecode
          logic [W-1:0] grpCode;
          assign grpCode = cfgVec[OFF +: W];
          for (genvar j = 0; j < SZ; j++) begin : gLeg
            assign legEn[k*GRP+j] = (grpCode == W'(j));
          end
        end
      end
      if (GRP_N > 1) begin : gStage
        localparam int SW   = $clog2(GRP_N);
        localparam int SOFF = selOffset(NUM_LEGS, GRP, GRP_N, 1'b1);
        logic [SW-1:0] stageCode;
        assign stageCode = cfgVec[SOFF +: SW];
        for (genvar k = 0; k < GRP_N; k++) begin : gStageEn
          assign grpEn[k] = (stageCode == SW'(k));
        end
      end else begin : gNoStage
        assign grpEn = '1;
      end
    end else begin : gHot
      assign legEn = cfgVec[NUM_LEGS-1:0];
      if (KIND == UNIT_IN && GRP_N > 1) begin : gStage
        assign grpEn = cfgVec[NUM_LEGS +: GRP_N];
      end else begin : gNoStage
        assign grpEn = '1;
      end
    end
  endgenerate

endmodule

// File: rtl/cbm_route.sv
`timescale 1ns/1ps
module cbm_route
  import cbm_pkg::*;
#(
  parameter unit_kind_e KIND     = UNIT_IN,
  parameter int         CHAN_W   = 16,
  parameter int         NUM_LEGS = 12,
  parameter int         GRP      = 8,
  parameter int         GRP_N    = 2,
  parameter int         IDX_W    = 4,
  parameter bit         USE_MAP  = 1'b0,
  parameter logic [NUM_LEGS*IDX_W-1:0] LEG_MAP = '0
) (
  input  logic [NUM_LEGS-1:0] legEn,
  input  logic [GRP_N-1:0]    grpEn,
  input  logic [CHAN_W-1:0]   chanIn,
  input  logic                pinIn,
  output logic                pinOut,
  output logic [CHAN_W-1:0]   chanOut
);

  function automatic int wireOf(input int i);
    return USE_MAP ? int'(LEG_MAP[i*IDX_W +: IDX_W]) : (i % CHAN_W);
  endfunction

  function automatic logic [NUM_LEGS-1:0] legsOnWire(input int w);
    logic [NUM_LEGS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LEGS; i++) m[i] = (wireOf(i) == w);
    return m;
  endfunction

  // input path: gated legs, OR inside each group, gated group OR
  logic [NUM_LEGS-1:0] legVal;
  logic [GRP_N-1:0]    grpHit;
  logic                muxOut;

  generate
    for (genvar i = 0; i < NUM_LEGS; i++) begin : gLegVal
      localparam int WI = wireOf(i);
      if (WI < CHAN_W) begin : gOn
        assign legVal[i] = legEn[i] & chanIn[WI];
      end else begin : gOff
        assign legVal[i] = 1'b0;
      end
    end
    for (genvar k = 0; k < GRP_N; k++) begin : gGrpHit
      localparam int SZ = grpSize(NUM_LEGS, GRP, k);
      assign grpHit[k] = |legVal[k*GRP +: SZ];
    end
  endgenerate

  assign muxOut = |(grpHit & grpEn);

  // output path: each wire driven by the pin when any leg on it is enabled
  logic [CHAN_W-1:0] demuxOut;

  generate
    for (genvar w = 0; w < CHAN_W; w++) begin : gWire
      localparam logic [NUM_LEGS-1:0] ON_WIRE = legsOnWire(w);
      assign demuxOut[w] = pinIn & (|(legEn & ON_WIRE));
    end
  endgenerate

  // passthrough path: direct neighbour link through leg 0
  logic passOut;
  assign passOut = pinIn & legEn[0];

  assign pinOut  = (KIND == UNIT_IN)   ? muxOut  :
                   (KIND == UNIT_PASS) ? passOut : 1'b0;
  assign chanOut = (KIND == UNIT_OUT)  ? demuxOut : '0;

endmodule

// File: rtl/conn_block_mux.sv
`timescale 1ns/1ps
module conn_block_mux
  import cbm_pkg::*;
#(
  parameter int         CHAN_W     = 16,
  parameter int         NUM_LEGS   = 12,
  parameter int         GRP        = 8,
  parameter unit_kind_e KIND       = UNIT_IN,
  parameter bit         SEL_DECODE = 1'b0,
  parameter bit         USE_MAP    = 1'b0,
  parameter logic [NUM_LEGS*$clog2(CHAN_W)-1:0] LEG_MAP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgShiftEn,
  input  logic              cfgDataIn,
  output logic              cfgDataOut,
  input  logic [CHAN_W-1:0] chanIn,
  input  logic              pinIn,
  output logic              pinOut,
  output logic [CHAN_W-1:0] chanOut
);

  localparam int IDX_W    = $clog2(CHAN_W);
  localparam int LEG_N    = (KIND == UNIT_PASS) ? 1 : NUM_LEGS;
  localparam int GRP_N    = (KIND == UNIT_IN) ? grpCount(NUM_LEGS, GRP) : 1;
  localparam bit USE_CODE = (KIND == UNIT_IN) && SEL_DECODE;
  localparam int CFG_BITS = cfgLength(KIND, LEG_N, GRP, USE_CODE);

  logic [CFG_BITS-1:0] cfgVec;
  logic [LEG_N-1:0]    legEn;
  logic [GRP_N-1:0]    grpEn;

  cbm_cfg_chain #(
    .LEN(CFG_BITS)
  ) uChain (
    .clk     (clk),
    .rstN    (rstN),
    .shiftEn (cfgShiftEn),
    .dataIn  (cfgDataIn),
    .cfgVec  (cfgVec),
    .dataOut (cfgDataOut)
  );

  cbm_select #(
    .KIND       (KIND),
    .NUM_LEGS   (LEG_N),
    .GRP        (GRP),
    .SEL_DECODE (USE_CODE),
    .GRP_N      (GRP_N),
    .CFG_BITS   (CFG_BITS)
  ) uSelect (
    .cfgVec (cfgVec),
    .legEn  (legEn),
    .grpEn  (grpEn)
  );

  cbm_route #(
    .KIND     (KIND),
    .CHAN_W   (CHAN_W),
    .NUM_LEGS (LEG_N),
    .GRP      (GRP),
    .GRP_N    (GRP_N),
    .IDX_W    (IDX_W),
    .USE_MAP  (USE_MAP),
    .LEG_MAP  (LEG_MAP[LEG_N*IDX_W-1:0])
  ) uRoute (
    .legEn   (legEn),
    .grpEn   (grpEn),
    .chanIn  (chanIn),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .chanOut (chanOut)
  );

endmodule

// File: rtl/cbm_checker.sv
`timescale 1ns/1ps
module cbm_checker
  import cbm_pkg::*;
#(
  parameter unit_kind_e KIND     = UNIT_IN,
  parameter int         CFG_BITS = 14,
  parameter int         NUM_LEGS = 12,
  parameter int         CHAN_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgShiftEn,
  input logic                cfgDataIn,
  input logic [CFG_BITS-1:0] cfgVec,
  input logic [NUM_LEGS-1:0] legEn,
  input logic                pinIn,
  input logic                pinOut,
  input logic [CHAN_W-1:0]   chanOut
);

  AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    cfgShiftEn |=> cfgVec[CFG_BITS-1] == $past(cfgDataIn)); // R1

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgShiftEn |=> $stable(cfgVec)); // R1

  generate
    if (CFG_BITS > 1) begin : gAdvance
      AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
        cfgShiftEn |=> cfgVec[CFG_BITS-2:0] == $past(cfgVec[CFG_BITS-1:1])); // R1
    end
  endgenerate

  AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (KIND == UNIT_IN && legEn == '0) |-> !pinOut); // R4

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (KIND == UNIT_OUT && !pinIn) |-> chanOut == '0); // R8

  AST_PASS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (KIND == UNIT_PASS && !legEn[0]) |-> !pinOut); // R9

endmodule

bind conn_block_mux cbm_checker #(
  .KIND     (KIND),
  .CFG_BITS (CFG_BITS),
  .NUM_LEGS (LEG_N),
  .CHAN_W   (CHAN_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgShiftEn (cfgShiftEn),
  .cfgDataIn  (cfgDataIn),
  .cfgVec     (cfgVec),
  .legEn      (legEn),
  .pinIn      (pinIn),
  .pinOut     (pinOut),
  .chanOut    (chanOut)
);

// File: tb/conn_block_mux_test.sv
`timescale 1ns/1ps
module conn_block_mux_test;
  import cbm_pkg::*;

  function automatic logic [47:0] mkMap12();
    logic [47:0] m;
    for (int i = 0; i < 12; i++) m[i*4 +: 4] = 4'((5 * i + 3) % 16);
    return m;
  endfunction

  localparam logic [47:0] MAP12 = mkMap12();
  localparam logic [17:0] MAP6  = {3'd3, 3'd7, 3'd0, 3'd5, 3'd2, 3'd2};
  localparam int OUT_WIRE [6] = '{2, 2, 5, 0, 7, 3};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgDataIn = 1'b0;
  logic [6:0]  shEn = '0;
  logic [6:0]  dOut;
  logic [6:0]  pOut;
  logic [15:0] chanA = '0;
  logic [7:0]  chanS = '0;
  logic        pinA = 1'b0;
  logic [15:0] cOut0, cOut1, cOut5, cOut6;
  logic [7:0]  cOut2, cOut3, cOut4;
  logic [15:0] lf = 16'hACE1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  conn_block_mux #(.CHAN_W(16), .NUM_LEGS(12), .KIND(UNIT_IN), .SEL_DECODE(1'b0),
    .USE_MAP(1'b1), .LEG_MAP(MAP12)) uut (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[0]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[0]),
    .chanIn(chanA), .pinIn(pinA), .pinOut(pOut[0]), .chanOut(cOut0));

  conn_block_mux #(.CHAN_W(16), .NUM_LEGS(12), .KIND(UNIT_IN), .SEL_DECODE(1'b1),
    .USE_MAP(1'b1), .LEG_MAP(MAP12)) uDec (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[1]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[1]),
    .chanIn(chanA), .pinIn(pinA), .pinOut(pOut[1]), .chanOut(cOut1));

  conn_block_mux #(.CHAN_W(8), .NUM_LEGS(5), .KIND(UNIT_IN)) uSmall (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[2]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[2]),
    .chanIn(chanS), .pinIn(pinA), .pinOut(pOut[2]), .chanOut(cOut2));

  conn_block_mux #(.CHAN_W(8), .NUM_LEGS(6), .KIND(UNIT_OUT), .USE_MAP(1'b1),
    .LEG_MAP(MAP6)) uOut (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[3]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[3]),
    .chanIn(chanS), .pinIn(pinA), .pinOut(pOut[3]), .chanOut(cOut3));

  conn_block_mux #(.CHAN_W(8), .NUM_LEGS(1), .KIND(UNIT_PASS)) uPass (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[4]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[4]),
    .chanIn(chanS), .pinIn(pinA), .pinOut(pOut[4]), .chanOut(cOut4));

  conn_block_mux #(.CHAN_W(16), .NUM_LEGS(20), .KIND(UNIT_IN), .SEL_DECODE(1'b0)) uWideHot (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[5]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[5]),
    .chanIn(chanA), .pinIn(pinA), .pinOut(pOut[5]), .chanOut(cOut5));

  conn_block_mux #(.CHAN_W(16), .NUM_LEGS(20), .KIND(UNIT_IN), .SEL_DECODE(1'b1)) uWideCode (
    .clk(clk), .rstN(rstN), .cfgShiftEn(shEn[6]), .cfgDataIn(cfgDataIn), .cfgDataOut(dOut[6]),
    .chanIn(chanA), .pinIn(pinA), .pinOut(pOut[6]), .chanOut(cOut6));

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ceilLog(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  // expected chain lengths from the stated formulas
  function automatic int expLenIn(input bit code, input int n);
    int groups;
    groups = (n + 7) / 8;
    if (!code) return (n <= 8) ? n : n + groups;
    if (n <= 8) return ceilLog(n);
    return (n / 8) * 3 + ((n % 8) != 0 ? ceilLog(n % 8) : 0) + ceilLog(groups);
  endfunction

  function automatic int wire12(input int i);
    return (5 * i + 3) % 16;
  endfunction

  task automatic nextRand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic loadCfg(input int k, input logic [31:0] bits, input int len);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      cfgDataIn = bits[b];
      shEn[k]   = 1'b1;
    end
    @(negedge clk);
    shEn[k]   = 1'b0;
    cfgDataIn = 1'b0;
  endtask

  task automatic measureLen(input int k, output int len);
    len = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      shEn[k]   = 1'b1;
      cfgDataIn = (c == 1);
      @(posedge clk);
      #1;
      if (dOut[k]) begin
        len = c;
        break;
      end
    end
    @(negedge clk);
    shEn[k]   = 1'b0;
    cfgDataIn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    logic [31:0] oh;
    logic [31:0] cd;
    logic [7:0]  expOut;
    int w;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state: all chains clear, nothing routed (R1)
    chanA = '1; chanS = '1; pinA = 1'b1;
    #2;
    check("R1", "reset chain ends", 32'(dOut), 32'h0);
    check("R4", "reset input unit pin", 32'(pOut[0]), 32'h0);
    check("R8", "reset output unit wires", 32'(cOut3), 32'h0);
    check("R9", "reset passthrough pin", 32'(pOut[4]), 32'h0);

    // chain lengths
    measureLen(0, len); check("R2", "len one-hot 12", 32'(len), 32'(expLenIn(1'b0, 12)));
    measureLen(1, len); check("R3", "len coded 12", 32'(len), 32'(expLenIn(1'b1, 12)));
    measureLen(2, len); check("R2", "len one-hot 5", 32'(len), 32'(expLenIn(1'b0, 5)));
    measureLen(3, len); check("R2", "len output 6", 32'(len), 32'd6);
    measureLen(4, len); check("R2", "len passthrough", 32'(len), 32'd1);
    measureLen(5, len); check("R2", "len one-hot 20", 32'(len), 32'(expLenIn(1'b0, 20)));
    measureLen(6, len); check("R3", "len coded 20", 32'(len), 32'(expLenIn(1'b1, 20)));
    check("R3", "coded 8 saves five", 32'(expLenIn(1'b0, 8) - expLenIn(1'b1, 8)), 32'd5);

    // every leg of the two-level unit, one-hot and coded (R5, R6, R7)
    for (int i = 0; i < 12; i++) begin
      oh = (32'd1 << i) | (32'd1 << (12 + i / 8));
      if (i < 8) cd = 32'(i);
      else       cd = (32'(i - 8) << 3) | 32'h20;
      loadCfg(0, oh, 14);
      loadCfg(1, cd, 6);
      w = wire12(i);
      for (int p = 0; p < 4; p++) begin
        if (p == 0)      chanA = 16'd1 << w;
        else if (p == 1) chanA = ~(16'd1 << w);
        else begin nextRand(); chanA = lf; end
        #2;
        check("R7", $sformatf("one-hot leg %0d pattern %0d", i, p), 32'(pOut[0]), 32'(chanA[w]));
        check("R6", $sformatf("coded leg %0d pattern %0d", i, p), 32'(pOut[1]), 32'(chanA[w]));
      end
      check("R1", "chain end after load", 32'(dOut[0]), 32'(oh[0]));
    end

    // group gate: legs 3 and 9 on, only group 0 enabled (R5)
    loadCfg(0, (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 12), 14);
    chanA = 16'd1 << wire12(9); #2;
    check("R5", "disabled group blocks leg 9", 32'(pOut[0]), 32'h0);
    chanA = 16'd1 << wire12(3); #2;
    check("R5", "enabled group passes leg 3", 32'(pOut[0]), 32'h1);

    // hold: shifting disabled keeps routing (R1)
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cfgDataIn = c[0];
    end
    #2;
    check("R1", "routing held with shift low", 32'(pOut[0]), 32'h1);
    cfgDataIn = 1'b0;

    // several legs combined by OR (R4)
    loadCfg(0, (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 12), 14);
    chanA = 16'd1 << wire12(5); #2;
    check("R4", "OR of legs, leg 5 high", 32'(pOut[0]), 32'h1);
    chanA = ~((16'd1 << wire12(2)) | (16'd1 << wire12(5))); #2;
    check("R4", "OR of legs, both low", 32'(pOut[0]), 32'h0);
    check("R10", "input unit wires quiet", 32'(cOut0), 32'h0);

    // coded stage picks group 1 while group 0 code points at leg 4 (R6)
    loadCfg(1, 32'h4 | (32'h1 << 3) | 32'h20, 6);
    chanA = 16'd1 << wire12(4); #2;
    check("R6", "stage blocks group 0", 32'(pOut[1]), 32'h0);
    chanA = 16'd1 << wire12(9); #2;
    check("R6", "stage passes leg 9", 32'(pOut[1]), 32'h1);

    // single-level unit, every setting, identity map (R4, R7)
    for (int c = 0; c < 32; c++) begin
      loadCfg(2, 32'(c), 5);
      for (int q = 0; q < 4; q++) begin
        nextRand();
        chanS = lf[7:0];
        #2;
        check("R4", $sformatf("single level cfg %0d", c), 32'(pOut[2]),
              32'(|(5'(c) & chanS[4:0])));
      end
    end

    // output unit, every subset of legs (R8)
    for (int c = 0; c < 64; c++) begin
      loadCfg(3, 32'(c), 6);
      for (int pv = 0; pv < 2; pv++) begin
        pinA = pv[0];
        expOut = '0;
        for (int i = 0; i < 6; i++) if (c[i] && pv == 1) expOut[OUT_WIRE[i]] = 1'b1;
        #2;
        check("R8", $sformatf("demux cfg %0d pin %0d", c, pv), 32'(cOut3), 32'(expOut));
      end
    end
    check("R8", "output unit pin low", 32'(pOut[3]), 32'h0);

    // passthrough (R9)
    for (int c = 0; c < 2; c++) begin
      loadCfg(4, 32'(c), 1);
      for (int pv = 0; pv < 2; pv++) begin
        pinA = pv[0];
        #2;
        check("R9", $sformatf("pass cfg %0d pin %0d", c, pv), 32'(pOut[4]), 32'(c & pv));
        check("R9", "pass wires quiet", 32'(cOut4), 32'h0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule